// File: doc/BRIEF.md
# Privilege and Page Permission Checker

This block decides, once per cycle, whether the operation presented by an execution pipeline is permitted under the current privilege level. It derives that level from the low bits of the code-segment selector, checks whether a privileged instruction is being issued outside the kernel level, and, when a memory access is valid, compares the access type against the permission bits of an already translated page entry. The page entry carries three bits: supervisor-only, writable and no-execute.

The result is registered. One cycle after the inputs are presented, the block drives a 3-bit fault code and an allow flag. The fault code reports the highest-priority violation found. The allow flag is high exactly when no fault is reported. Writes to read-only pages made at the kernel level are blocked only while a global write-protect enable is set. The pipeline uses the fault code to pick a trap kind and uses allow to let the operation commit.

Top module: `priv_perm_check`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, fault_o is 0 and allow_o is 1.
- R2: The privilege level is the value of seg_sel_i[1:0]. Level 0 is the kernel level, and the upper selector bits have no effect on the result.
- R3: When instr_priv_i is high and the level is not 0, the fault code is 1 (general protection), whatever the memory inputs are.
- R4: When mem_vld_i is high, the level is not 0 and pg_sup_i is 1, the fault code is 2 (supervisor violation), unless R3 applies.
- R5: A write (acc_kind_i = 01) with mem_vld_i high to a page with pg_wr_i = 0 gives fault code 3 when the level is not 0 or wp_en_i is 1. At level 0 with wp_en_i = 0 the write is allowed.
- R6: A fetch (acc_kind_i = 10) with mem_vld_i high from a page with pg_nx_i = 1 gives fault code 4 at any level.
- R7: Priority runs from highest to lowest as general protection, then supervisor, then write, then no-execute. Reads use acc_kind_i = 00, and the code 11 is treated as a read.
- R8: When mem_vld_i is low, the page bits and the access kind have no effect, and only the privileged-instruction check can fault.
- R9: fault_o and allow_o reflect the inputs sampled at the previous rising clock edge. allow_o is 1 exactly when fault_o is 0.
- R10: Reads, writes and fetches to a user page that is writable and executable are allowed at level 0 and at level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_sel_i | input | SEL_W | Code-segment selector; the low LVL_W bits give the level |
| instr_priv_i | input | 1 | Current instruction is privileged |
| mem_vld_i | input | 1 | A memory access accompanies the instruction |
| acc_kind_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| pg_sup_i | input | 1 | Page is supervisor-only |
| pg_wr_i | input | 1 | Page is writable |
| pg_nx_i | input | 1 | Page is no-execute |
| wp_en_i | input | 1 | Global write-protect enable for kernel writes |
| allow_o | output | 1 | Operation permitted (registered) |
| fault_o | output | 3 | Fault code: 0 none, 1 GP, 2 supervisor, 3 write, 4 no-execute (registered) |

## Verification
Every result is due exactly one rising edge after its inputs are driven. The driver applies each stimulus on a falling edge and pushes the expected code into a queue. The monitor pops that entry one time unit after the next rising edge and compares it against both outputs, so stimulus and comparison can never drift apart by a cycle. The reset values are sampled during reset and again after reset is released, before any stimulus is applied. Directed cases cover each priority collision, and an exhaustive sweep covers every input combination at two selector values per level.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

   localparam int FLT_W = 3;

   typedef enum logic [FLT_W-1:0] {
      FLT_NONE = 3'd0,
      FLT_GP   = 3'd1,
      FLT_SUP  = 3'd2,
      FLT_WR   = 3'd3,
      FLT_NX   = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   typedef struct packed {
      logic sup;
      logic wr;
      logic nx;
   } mem_viol_t;

endpackage

// File: rtl/ppc_level_decode.sv
module ppc_level_decode #(
   parameter int SEL_W    = 16,
   parameter int LVL_W    = 2,
   parameter int KERN_LVL = 0
) (
   input  logic [SEL_W-1:0] seg_sel_i,
   output logic [LVL_W-1:0] level_o,
   output logic             is_kern_o
);

   generate
      if (LVL_W == SEL_W) begin : g_full
         assign level_o = seg_sel_i;
      end else begin : g_slice
         assign level_o = seg_sel_i[LVL_W-1:0];
      end
   endgenerate

   localparam logic [LVL_W-1:0] KERN_CODE = LVL_W'(KERN_LVL);

   assign is_kern_o = (level_o == KERN_CODE);

endmodule

// File: rtl/ppc_mem_eval.sv
module ppc_mem_eval
   import ppc_pkg::*;
(
   input  logic      mem_vld_i,
   input  logic      is_kern_i,
   input  logic [1:0] acc_kind_i,
   input  logic      pg_sup_i,
   input  logic      pg_wr_i,
   input  logic      pg_nx_i,
   input  logic      wp_en_i,
   output mem_viol_t viol_o
);

   logic is_write;
   logic is_fetch;

   always_comb begin
      is_write = (acc_kind_i == ACC_WRITE);
      is_fetch = (acc_kind_i == ACC_FETCH);
      viol_o.sup = mem_vld_i & pg_sup_i & ~is_kern_i;
      viol_o.wr  = mem_vld_i & is_write & ~pg_wr_i & (~is_kern_i | wp_en_i);
      viol_o.nx  = mem_vld_i & is_fetch & pg_nx_i;
   end

endmodule

// File: rtl/ppc_fault_reg.sv
module ppc_fault_reg
   import ppc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      gp_viol_i,
   input  mem_viol_t mem_viol_i,
   output logic      allow_o,
   output fault_e    fault_o
);

   fault_e nxt_fault;

   always_comb begin
      if (gp_viol_i)           nxt_fault = FLT_GP;
      else if (mem_viol_i.sup) nxt_fault = FLT_SUP;
      else if (mem_viol_i.wr)  nxt_fault = FLT_WR;
      else if (mem_viol_i.nx)  nxt_fault = FLT_NX;
      else                     nxt_fault = FLT_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fault_o <= FLT_NONE;
         allow_o <= 1'b1;
      end else begin
         fault_o <= nxt_fault;
         allow_o <= ~(gp_viol_i | mem_viol_i.sup | mem_viol_i.wr | mem_viol_i.nx);
      end
   end

endmodule

// File: rtl/priv_perm_check.sv
module priv_perm_check
   import ppc_pkg::*;
#(
   parameter int SEL_W    = 16,
   parameter int LVL_W    = 2,
   parameter int KERN_LVL = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] seg_sel_i,
   input  logic             instr_priv_i,
   input  logic             mem_vld_i,
   input  logic [1:0]       acc_kind_i,
   input  logic             pg_sup_i,
   input  logic             pg_wr_i,
   input  logic             pg_nx_i,
   input  logic             wp_en_i,
   output logic             allow_o,
   output logic [FLT_W-1:0] fault_o
);

   generate
      if (LVL_W < 1 || LVL_W > SEL_W) begin : g_bad_lvl_w
         $error("priv_perm_check: LVL_W must lie in 1..SEL_W");
      end
      if (KERN_LVL < 0 || KERN_LVL >= (1 << LVL_W)) begin : g_bad_kern
         $error("priv_perm_check: KERN_LVL does not fit in LVL_W bits");
      end
   endgenerate

   logic [LVL_W-1:0] level;
   logic             is_kern;
   mem_viol_t        mem_viol;
   fault_e           fault_q;

   ppc_level_decode #(
      .SEL_W    (SEL_W),
      .LVL_W    (LVL_W),
      .KERN_LVL (KERN_LVL)
   ) u_lvl (
      .seg_sel_i (seg_sel_i),
      .level_o   (level),
      .is_kern_o (is_kern)
   );

   ppc_mem_eval u_mem (
      .mem_vld_i  (mem_vld_i),
      .is_kern_i  (is_kern),
      .acc_kind_i (acc_kind_i),
      .pg_sup_i   (pg_sup_i),
      .pg_wr_i    (pg_wr_i),
      .pg_nx_i    (pg_nx_i),
      .wp_en_i    (wp_en_i),
      .viol_o     (mem_viol)
   );

   ppc_fault_reg u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gp_viol_i  (instr_priv_i & ~is_kern),
      .mem_viol_i (mem_viol),
      .allow_o    (allow_o),
      .fault_o    (fault_q)
   );

   assign fault_o = fault_q;

   logic unused_lvl;
   assign unused_lvl = ^level;

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
   parameter int SEL_W    = 16,
   parameter int LVL_W    = 2,
   parameter int KERN_LVL = 0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [SEL_W-1:0] seg_sel_i,
   input logic             instr_priv_i,
   input logic             mem_vld_i,
   input logic [1:0]       acc_kind_i,
   input logic             pg_sup_i,
   input logic             pg_wr_i,
   input logic             pg_nx_i,
   input logic             wp_en_i,
   input logic             allow_o,
   input logic [2:0]       fault_o
);

   logic user_lvl;
   assign user_lvl = (seg_sel_i[LVL_W-1:0] != LVL_W'(KERN_LVL));

   AST_ALLOW_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      allow_o == (fault_o == 3'd0)); // R9

   AST_GP_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && instr_priv_i && user_lvl) |=> (fault_o == 3'd1)); // R3

   AST_SUP_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && !instr_priv_i && mem_vld_i && pg_sup_i && user_lvl) |=> (fault_o == 3'd2)); // R4

   AST_KERN_WR_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && mem_vld_i && !user_lvl && !wp_en_i && acc_kind_i == 2'b01)
      |=> (fault_o == 3'd0)); // R5

   AST_NX_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && !instr_priv_i && mem_vld_i && !(pg_sup_i && user_lvl) && acc_kind_i == 2'b10 && pg_nx_i)
      |=> (fault_o == 3'd4)); // R6

   AST_IDLE_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_ni && !mem_vld_i && !(instr_priv_i && user_lvl)) |=> (fault_o == 3'd0)); // R8

   AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o <= 3'd4); // R7

endmodule

bind priv_perm_check ppc_checker #(
   .SEL_W    (SEL_W),
   .LVL_W    (LVL_W),
   .KERN_LVL (KERN_LVL)
) u_chk (.*);

// File: tb/priv_perm_check_bench.sv
module priv_perm_check_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] seg_sel = '0;
   logic        instr_priv = 1'b0;
   logic        mem_vld = 1'b0;
   logic [1:0]  acc_kind = 2'b00;
   logic        pg_sup = 1'b0;
   logic        pg_wr = 1'b0;
   logic        pg_nx = 1'b0;
   logic        wp_en = 1'b0;
   logic        allow;
   logic [2:0]  fault;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [2:0] code;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   priv_perm_check u_priv_perm_check (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .seg_sel_i    (seg_sel),
      .instr_priv_i (instr_priv),
      .mem_vld_i    (mem_vld),
      .acc_kind_i   (acc_kind),
      .pg_sup_i     (pg_sup),
      .pg_wr_i      (pg_wr),
      .pg_nx_i      (pg_nx),
      .wp_en_i      (wp_en),
      .allow_o      (allow),
      .fault_o      (fault)
   );

   function automatic logic [2:0] model(logic [15:0] sel, logic pr, logic mv, logic [1:0] k,
                                        logic s, logic w, logic x, logic wp);
      logic usr;
      usr = (sel[1:0] != 2'd0);
      if (pr && usr)                               return 3'd1;
      if (mv && s && usr)                          return 3'd2;
      if (mv && k == 2'b01 && !w && (usr || wp))   return 3'd3;
      if (mv && k == 2'b10 && x)                   return 3'd4;
      return 3'd0;
   endfunction

   task automatic check(string tag, logic [2:0] exp_code);
      n_checks++;
      if (fault !== exp_code || allow !== (exp_code == 3'd0)) begin
         n_errors++;
         $display("FAIL %s: fault=%0d allow=%0b expected fault=%0d allow=%0b",
                  tag, fault, allow, exp_code, exp_code == 3'd0);
      end
   endtask

   task automatic drive(string tag, logic [15:0] sel, logic pr, logic mv, logic [1:0] k,
                        logic s, logic w, logic x, logic wp, logic [2:0] exp_code);
      exp_t e;
      @(negedge clk);
      seg_sel = sel; instr_priv = pr; mem_vld = mv; acc_kind = k;
      pg_sup = s; pg_wr = w; pg_nx = x; wp_en = wp;
      e.code = exp_code;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // monitor: pops one expectation per edge, one time unit after it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, e.code);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 during reset", 3'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 3'd0);

      drive("R2 kernel sel 0x0010 privileged", 16'h0010, 1, 0, 2'b00, 0, 0, 0, 0, 3'd0);
      drive("R2 user sel 0x0033 privileged",   16'h0033, 1, 0, 2'b00, 0, 0, 0, 0, 3'd1);
      drive("R3 level1 priv beats sup page",   16'h0001, 1, 1, 2'b01, 1, 0, 1, 1, 3'd1);
      drive("R3 level2 privileged",            16'h0002, 1, 0, 2'b00, 0, 1, 0, 0, 3'd1);
      drive("R4 user read sup page",           16'h0003, 0, 1, 2'b00, 1, 1, 0, 0, 3'd2);
      drive("R4 kernel read sup page",         16'h0000, 0, 1, 2'b00, 1, 1, 0, 0, 3'd0);
      drive("R7 sup beats write",              16'h0033, 0, 1, 2'b01, 1, 0, 0, 0, 3'd2);
      drive("R5 user write read-only",         16'h0033, 0, 1, 2'b01, 0, 0, 0, 0, 3'd3);
      drive("R5 kernel write ro wp off",       16'h0010, 0, 1, 2'b01, 0, 0, 0, 0, 3'd0);
      drive("R5 kernel write ro wp on",        16'h0010, 0, 1, 2'b01, 0, 0, 0, 1, 3'd3);
      drive("R6 kernel fetch nx",              16'h0010, 0, 1, 2'b10, 0, 1, 1, 0, 3'd4);
      drive("R6 user fetch nx",                16'h0033, 0, 1, 2'b10, 0, 1, 1, 0, 3'd4);
      drive("R7 sup beats nx",                 16'h0033, 0, 1, 2'b10, 1, 1, 1, 0, 3'd2);
      drive("R7 reserved kind as read",        16'h0033, 0, 1, 2'b11, 0, 0, 1, 1, 3'd0);
      drive("R8 invalid mem ignores bits",     16'h0033, 0, 0, 2'b01, 1, 0, 1, 1, 3'd0);
      drive("R10 kernel user-page write",      16'h0010, 0, 1, 2'b01, 0, 1, 0, 1, 3'd0);
      drive("R10 user user-page fetch",        16'h0033, 0, 1, 2'b10, 0, 1, 0, 0, 3'd0);
      drive("R10 user user-page read",         16'h0003, 0, 1, 2'b00, 0, 1, 0, 0, 3'd0);

      for (int lv = 0; lv < 4; lv++) begin
         for (int hi = 0; hi < 2; hi++) begin
            for (int v = 0; v < 256; v++) begin
               logic [15:0] sel;
               logic [7:0]  b;
               b   = 8'(v);
               sel = (hi != 0) ? (16'hA5A4 | 16'(lv)) : 16'(lv);
               drive("R9 sweep", sel, b[0], b[1], b[3:2], b[4], b[5], b[6], b[7],
                     model(sel, b[0], b[1], b[3:2], b[4], b[5], b[6], b[7]));
            end
         end
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule